// File: doc/BRIEF.md
# Video Test Pattern Colour Generator

This block sits downstream of a raster sync generator. Each pixel clock it receives the current horizontal and vertical pixel counts and a flag that says whether the beam is inside the visible window. From these it produces a packed RGB colour word that shows one of four test images. A two-bit select input picks the image: coloured vertical bars, a black-and-white checkerboard, thin white diagonal lines, or a flat white field. The colour depends only on the coordinates and the select input. No memory is read.

Every channel is either fully on or fully off. This keeps the images identical across both output packings. A build parameter chooses the packing. The narrow form gives red three bits, green three and blue two. The wide form gives each channel four bits. Outside the visible window the word is held at zero, so blanking always shows black. The output is registered, so it trails the counts by exactly one clock. The sync stage must delay its own sync pulses by one cycle to stay aligned with the colour.

Top module: `vga_test_pattern`

## Requirements
- R1: While the active-low reset `rstN` is asserted, `rgbOut` is all zeros.
- R2: When `active` is low, `rgbOut` is all zeros (black) one cycle later, whatever the select value and counts.
- R3: With `WIDE_PIX` = 0, `rgbOut` is 8 bits wide. Red is bits [7:5], green is bits [4:2] and blue is bits [1:0].
- R4: With `WIDE_PIX` = 1, `rgbOut` is 12 bits wide. Red is bits [11:8], green is bits [7:4] and blue is bits [3:0].
- R5: With `patSel` = 00 (bars), red is all ones when `hCount[7]` is 1, green when `hCount[6]` is 1 and blue when `hCount[5]` is 1. Each channel is all zeros otherwise.
- R6: With `patSel` = 01 (checkerboard), the pixel is white (all bits one) when `hCount[5]` XOR `vCount[5]` is 1, and black otherwise.
- R7: With `patSel` = 10 (diagonals), the pixel is white when `hCount[5:0]` equals `vCount[5:0]`, and black otherwise.
- R8: With `patSel` = 11, every active pixel is white.
- R9: `rgbOut` reflects the inputs sampled at the previous rising clock edge. A change on the inputs does not alter `rgbOut` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hCount | input | H_W (10) | Horizontal pixel count |
| vCount | input | V_W (10) | Vertical line count |
| active | input | 1 | High inside the visible window |
| patSel | input | 2 | Test image select: 00 bars, 01 checker, 10 diagonals, 11 white |
| rgbOut | output | 8 or 12 | Packed colour, red in the MSBs and blue in the LSBs |

## Verification
Random coordinates spread over the whole count range are applied under all four select codes, both inside and outside the window. This separates gating errors from pattern errors. Directed points sit on the checker edges (counts 31/32 and 63/64) and on the diagonal match, including vertical counts that differ only above bit 5. These points tell a correct bit choice from an off-by-one bit choice. Both packings are driven with the same stimulus, so a mistake in the channel order shows up as a mismatch on the 3/3/2 layout or on the 4/4/4 layout. Every stimulus change is also sampled before the next clock edge, which separates a registered output from a combinational one.

// File: rtl/vga_tp_pkg.sv
package vga_tp_pkg;

  typedef enum logic [1:0] {
    PAT_BARS    = 2'b00,
    PAT_CHECKER = 2'b01,
    PAT_DIAG    = 2'b10,
    PAT_WHITE   = 2'b11
  } patSel_e;

  // Strobes from the select decoder to the colour datapath
  typedef struct packed {
    logic gate;
    logic selBars;
    logic selChecker;
    logic selDiag;
    logic selWhite;
  } patStrb_t;

endpackage

// File: rtl/vga_tp_ctrl.sv
module vga_tp_ctrl
  import vga_tp_pkg::*;
(
  input  logic [1:0] patSel,
  input  logic       active,
  output patStrb_t   strb
);

  patSel_e selCode;

  always_comb begin
    selCode         = patSel_e'(patSel);
    strb            = '0;
    strb.gate       = active;
    unique case (selCode)
      PAT_BARS:    strb.selBars    = 1'b1;
      PAT_CHECKER: strb.selChecker = 1'b1;
      PAT_DIAG:    strb.selDiag    = 1'b1;
      PAT_WHITE:   strb.selWhite   = 1'b1;
      default:     strb            = '0;
    endcase
  end

endmodule

// File: rtl/vga_tp_dpath.sv
module vga_tp_dpath
  import vga_tp_pkg::*;
#(
  parameter int H_W       = 10,
  parameter int V_W       = 10,
  parameter bit WIDE_PIX  = 1'b0,
  parameter int BAR_LSB   = 5,
  parameter int CHECK_BIT = 5,
  parameter int DIAG_BITS = 6,
  localparam int R_W      = WIDE_PIX ? 4 : 3,
  localparam int G_W      = WIDE_PIX ? 4 : 3,
  localparam int B_W      = WIDE_PIX ? 4 : 2,
  localparam int PIX_W    = R_W + G_W + B_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [H_W-1:0]   hCount,
  input  logic [V_W-1:0]   vCount,
  input  patStrb_t         strb,
  output logic [PIX_W-1:0] rgbQ
);

  logic rOn, gOn, bOn;
  logic checkOn, diagOn;
  logic [PIX_W-1:0] pixNext;

  assign checkOn = hCount[CHECK_BIT] ^ vCount[CHECK_BIT];
  assign diagOn  = (hCount[DIAG_BITS-1:0] == vCount[DIAG_BITS-1:0]);

  always_comb begin
    {rOn, gOn, bOn} = 3'b000;
    if (strb.gate) begin
      if (strb.selBars)         {rOn, gOn, bOn} = hCount[BAR_LSB +: 3];
      else if (strb.selChecker) {rOn, gOn, bOn} = {3{checkOn}};
      else if (strb.selDiag)    {rOn, gOn, bOn} = {3{diagOn}};
      else if (strb.selWhite)   {rOn, gOn, bOn} = 3'b111;
    end
  end

  // Channel packing: red high, blue low; widths follow WIDE_PIX
  generate
    if (WIDE_PIX) begin : g_pack12
      assign pixNext = {{R_W{rOn}}, {G_W{gOn}}, {B_W{bOn}}};
    end else begin : g_pack8
      assign pixNext = {{R_W{rOn}}, {G_W{gOn}}, {B_W{bOn}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rgbQ <= '0;
    else       rgbQ <= pixNext;
  end

  // R2: blanking gives black
  a_r2_blank_black: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strb.gate) |-> rgbQ == '0);

  // R5: bar channels follow the count bits
  a_r5_bar_bits: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && strb.gate && strb.selBars) |->
      (rgbQ[PIX_W-1] == $past(hCount[BAR_LSB+2])) && (rgbQ[0] == $past(hCount[BAR_LSB])));

  // R6: checkerboard is only black or white
  a_r6_checker_bw: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && strb.gate && strb.selChecker) |-> (rgbQ == '0 || &rgbQ));

  // R7: off-diagonal pixels are black
  a_r7_diag_off: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && strb.gate && strb.selDiag &&
          (hCount[DIAG_BITS-1:0] != vCount[DIAG_BITS-1:0])) |-> rgbQ == '0);

  // R8: flat field is white
  a_r8_white: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && strb.gate && strb.selWhite) |-> &rgbQ);

endmodule

// File: rtl/vga_test_pattern.sv
module vga_test_pattern
  import vga_tp_pkg::*;
#(
  parameter int H_W      = 10,
  parameter int V_W      = 10,
  parameter bit WIDE_PIX = 1'b0,
  localparam int PIX_W   = WIDE_PIX ? 12 : 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [H_W-1:0]   hCount,
  input  logic [V_W-1:0]   vCount,
  input  logic             active,
  input  logic [1:0]       patSel,
  output logic [PIX_W-1:0] rgbOut
);

  patStrb_t strb;

  vga_tp_ctrl ctrl_i (
    .patSel (patSel),
    .active (active),
    .strb   (strb)
  );

  vga_tp_dpath #(
    .H_W      (H_W),
    .V_W      (V_W),
    .WIDE_PIX (WIDE_PIX)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .hCount (hCount),
    .vCount (vCount),
    .strb   (strb),
    .rgbQ   (rgbOut)
  );

endmodule

// File: tb/vga_test_pattern_tb_top.sv
module vga_test_pattern_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] hCount = '0;
  logic [9:0] vCount = '0;
  logic       active = 1'b0;
  logic [1:0] patSel = 2'b00;
  logic [7:0]  rgb8;
  logic [11:0] rgb12;

  int checks = 0;
  int errors = 0;
  logic [11:0] prevExp12 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_test_pattern #(.WIDE_PIX(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .active(active), .patSel(patSel), .rgbOut(rgb8));

  vga_test_pattern #(.WIDE_PIX(1'b1)) dut12_i (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .active(active), .patSel(patSel), .rgbOut(rgb12));

  // Channel on/off flags {r,g,b} from the requirements
  function automatic logic [2:0] expRgb(input logic [9:0] h, input logic [9:0] v,
                                        input logic a, input logic [1:0] p);
    if (!a) return 3'b000;
    case (p)
      2'b00:   return h[7:5];
      2'b01:   return {3{h[5] ^ v[5]}};
      2'b10:   return {3{h[5:0] == v[5:0]}};
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [7:0] pack8(input logic [2:0] c);
    return {{3{c[2]}}, {3{c[1]}}, {2{c[0]}}};
  endfunction

  function automatic logic [11:0] pack12(input logic [2:0] c);
    return {{4{c[2]}}, {4{c[1]}}, {4{c[0]}}};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, check hold (R9), then check after the next rising edge
  task automatic apply(input logic [9:0] h, input logic [9:0] v, input logic a,
                       input logic [1:0] p, input string req);
    logic [2:0] c;
    hCount = h; vCount = v; active = a; patSel = p;
    #1;
    chk("R9 hold", rgb12, prevExp12);
    c = expRgb(h, v, a, p);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R3"}, {4'h0, rgb8}, {4'h0, pack8(c)});
    chk({req, " R4"}, rgb12, pack12(c));
    prevExp12 = pack12(c);
  endtask

  initial begin
    active = 1'b1; patSel = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset 8b", {4'h0, rgb8}, 12'h000);
    chk("R1 reset 12b", rgb12, 12'h000);
    active = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    prevExp12 = '0;

    // R8 white and R3/R4 packing
    apply(10'd5, 10'd9, 1'b1, 2'b11, "R8");
    // R2 blanking under every pattern
    apply(10'd0, 10'd0, 1'b0, 2'b11, "R2");
    apply(10'd224, 10'd3, 1'b0, 2'b00, "R2");
    apply(10'd40, 10'd40, 1'b0, 2'b10, "R2");
    apply(10'd32, 10'd0, 1'b0, 2'b01, "R2");
    // R5 each bar
    for (int i = 0; i < 8; i++) apply(10'(i * 32 + 7), 10'd100, 1'b1, 2'b00, "R5");
    apply(10'd256, 10'd1, 1'b1, 2'b00, "R5");
    // R6 checker edges
    apply(10'd31, 10'd0, 1'b1, 2'b01, "R6");
    apply(10'd32, 10'd0, 1'b1, 2'b01, "R6");
    apply(10'd32, 10'd32, 1'b1, 2'b01, "R6");
    apply(10'd63, 10'd64, 1'b1, 2'b01, "R6");
    apply(10'd64, 10'd31, 1'b1, 2'b01, "R6");
    // R7 diagonal
    apply(10'd37, 10'd37, 1'b1, 2'b10, "R7");
    apply(10'd37, 10'd101, 1'b1, 2'b10, "R7");
    apply(10'd37, 10'd38, 1'b1, 2'b10, "R7");
    apply(10'd0, 10'd64, 1'b1, 2'b10, "R7");
    apply(10'd63, 10'd31, 1'b1, 2'b10, "R7");
    // Random mix
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 400; i++) begin
      apply(10'($urandom), 10'($urandom), ($urandom % 4) != 0, 2'($urandom), "R2/R5-R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule